// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN node that has gone bus-off may take part in bus traffic again. A one-cycle entry pulse from the error logic puts the block into the bus-off state. From then on it watches the sampled receive bit stream, one bit per cycle on which a valid strobe is high, and counts runs of eleven consecutive recessive bits. A dominant bit breaks the run in progress. Each completed run of eleven adds one to an occurrence count, and the next run starts from zero.

Recovery needs 128 such occurrences. A mode input selects how the exit is taken. In automatic mode the block leaves bus-off as soon as the 128th run completes. In manual mode it also waits until software has raised and then lowered an initialization-request level. The handshake may come before or after the runs finish. On exit the block drops its bus-off status and issues a one-cycle pulse that tells the error counters to reset. The mode has no effect on how bus-off is entered.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, busOff and errCntReset are both 0.
- R2: A high busOffEntry on a clock edge sets busOff from the next cycle, in either mode, with errCntReset low. Entry has priority over an exit in the same cycle.
- R3: In automatic mode (autoRecover=1), busOff falls on the second clock edge after the edge that samples the final bit of the 128th run. It does not fall earlier.
- R4: A valid dominant bit (rxBit=0) sets the current run length to zero. Recessive bits before it in that run count for nothing.
- R5: Consecutive recessive bits with no dominant bit between them form back-to-back runs. 1408 such bits count as exactly 128 runs. The occurrence count saturates at 128.
- R6: A cycle with bitValid=0 has no effect on the run or the count, whatever rxBit holds.
- R7: In manual mode (autoRecover=0), 128 runs or more alone never end bus-off. Once the runs are done, a set-then-clear of initReq ends bus-off two edges after the edge that samples initReq low.
- R8: In manual mode, a handshake completed before the 128th run is remembered. busOff then falls on the second edge after the edge that samples the final bit of that run.
- R9: In manual mode, initReq held high, or held low throughout, never completes the handshake.
- R10: errCntReset is high for exactly one cycle, and that is the first cycle in which busOff is low after bus-off.
- R11: A new entry pulse clears the run length, the occurrence count and any handshake progress. Bits seen while not in bus-off are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busOffEntry | input | 1 | One-cycle pulse: node has entered bus-off |
| bitValid | input | 1 | rxBit holds a newly sampled bus bit this cycle |
| rxBit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| autoRecover | input | 1 | 1 = leave bus-off by hardware, 0 = wait for the handshake |
| initReq | input | 1 | Software initialization-request level |
| busOff | output | 1 | Node is in the bus-off state |
| errCntReset | output | 1 | One-cycle pulse on recovery |

## Verification
The bench sweeps a dominant bit across every position of the final run. A design that forgets to clear the partial run would exit early, and one that clears the occurrence count instead would never exit. Invalid dominant cycles are placed between valid bits to catch logic that ignores the strobe. That logic would reset runs and never recover. In manual mode the bench checks the handshake both before and after the runs finish, as well as a level held high or held low. A design that treats the level as a trigger, or forgets an early handshake, either leaves too soon or hangs. Re-entry after partial progress must restart the full 1408-bit count, so stale counts show up as an early exit.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef struct packed {
    logic countEn;   // bits are being counted (in bus-off)
    logic clearAll;  // restart run and occurrence counters
  } borStrobes_t;
endpackage

// File: rtl/can_bor_datapath.sv
module can_bor_datapath
  import can_bor_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  borStrobes_t strobes,
  input  logic        bitValid,
  input  logic        rxBit,
  output logic        runsDone
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int OCC_W = $clog2(RUN_COUNT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(RUN_COUNT);

  logic [RUN_W-1:0] runLen;
  logic [OCC_W-1:0] occCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      occCnt <= '0;
    end else if (strobes.clearAll) begin
      runLen <= '0;
      occCnt <= '0;
    end else if (strobes.countEn && bitValid) begin
      if (!rxBit) begin
        runLen <= '0;
      end else if (runLen == RUN_LAST) begin
        runLen <= '0;
        if (occCnt != OCC_MAX) occCnt <= occCnt + 1'b1;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign runsDone = (occCnt == OCC_MAX);

  p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= RUN_LAST);
  p_dominant_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.clearAll && bitValid && !rxBit) |=> runLen == '0);
  p_occ_saturates_r5: assert property (@(posedge clk) disable iff (!rstN)
    occCnt <= OCC_MAX);
  p_invalid_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !strobes.clearAll) |=> $stable(runLen) && $stable(occCnt));
  p_idle_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.countEn |=> occCnt == '0 || strobes.countEn);
endmodule

// File: rtl/can_bor_control.sv
module can_bor_control
  import can_bor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busOffEntry,
  input  logic        autoRecover,
  input  logic        initReq,
  input  logic        runsDone,
  output borStrobes_t strobes,
  output logic        busOff,
  output logic        errCntReset
);
  logic busOffQ, hsSetQ, hsDoneQ, pulseQ;
  logic exitNow;

  assign exitNow = busOffQ && !busOffEntry && runsDone && (autoRecover || hsDoneQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOffQ <= 1'b0;
      hsSetQ  <= 1'b0;
      hsDoneQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else if (busOffEntry) begin
      busOffQ <= 1'b1;
      hsSetQ  <= 1'b0;
      hsDoneQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else if (exitNow) begin
      busOffQ <= 1'b0;
      hsSetQ  <= 1'b0;
      hsDoneQ <= 1'b0;
      pulseQ  <= 1'b1;
    end else begin
      pulseQ <= 1'b0;
      if (busOffQ) begin
        if (initReq) hsSetQ <= 1'b1;
        else if (hsSetQ) hsDoneQ <= 1'b1;
      end
    end
  end

  assign strobes.countEn  = busOffQ;
  assign strobes.clearAll = busOffEntry || exitNow;
  assign busOff      = busOffQ;
  assign errCntReset = pulseQ;

  p_entry_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    busOffEntry |=> busOff && !errCntReset);
  p_exit_needs_runs_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> $past(runsDone));
  p_manual_needs_hs_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busOff) && !$past(autoRecover)) |-> $past(hsSetQ));
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    errCntReset |=> !errCntReset);
  p_pulse_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    errCntReset |-> !busOff);
  p_fall_gives_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> errCntReset);
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import can_bor_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic busOffEntry,
  input  logic bitValid,
  input  logic rxBit,
  input  logic autoRecover,
  input  logic initReq,
  output logic busOff,
  output logic errCntReset
);
  borStrobes_t strobes;
  logic        runsDone;

  can_bor_control u_ctrl (
    .clk(clk), .rstN(rstN), .busOffEntry(busOffEntry),
    .autoRecover(autoRecover), .initReq(initReq), .runsDone(runsDone),
    .strobes(strobes), .busOff(busOff), .errCntReset(errCntReset)
  );

  can_bor_datapath #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .bitValid(bitValid), .rxBit(rxBit), .runsDone(runsDone)
  );
endmodule

// File: tb/tb_can_busoff_recovery.sv
module tb_can_busoff_recovery;
  localparam int RUN_LEN = 11;
  localparam int RUN_COUNT = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busOffEntry = 1'b0, bitValid = 1'b0, rxBit = 1'b1;
  logic autoRecover = 1'b1, initReq = 1'b0;
  logic busOff, errCntReset;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) dut (
    .clk(clk), .rstN(rstN), .busOffEntry(busOffEntry), .bitValid(bitValid),
    .rxBit(rxBit), .autoRecover(autoRecover), .initReq(initReq),
    .busOff(busOff), .errCntReset(errCntReset)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enter(input bit mode);
    @(negedge clk);
    autoRecover = mode;
    busOffEntry = 1'b1;
    @(negedge clk);
    busOffEntry = 1'b0;
    check(busOff === 1'b1 && errCntReset === 1'b0, "R2 entry", int'(busOff), 1);
  endtask

  // Drive n valid bits of one level; optionally an invalid dominant cycle after each.
  task automatic feed(input int n, input bit lvl, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitValid = 1'b1; rxBit = lvl;
      if (gaps) begin
        @(negedge clk);
        bitValid = 1'b0; rxBit = 1'b0;
      end
    end
    @(negedge clk);
    bitValid = 1'b0; rxBit = 1'b1;
  endtask

  // busOff high for n-1 more negedges, low with pulse on the n-th, pulse gone after.
  task automatic expectExit(input int n, input string tag);
    for (int i = 1; i < n; i++) begin
      check(busOff === 1'b1, {tag, " not early"}, int'(busOff), 1);
      @(negedge clk);
    end
    check(busOff === 1'b1, {tag, " still bus-off"}, int'(busOff), 1);
    @(negedge clk);
    check(busOff === 1'b0 && errCntReset === 1'b1, {tag, " exit R10 pulse"},
          int'({busOff, errCntReset}), 1);
    @(negedge clk);
    check(errCntReset === 1'b0 && busOff === 1'b0, {tag, " R10 single pulse"},
          int'(errCntReset), 0);
  endtask

  task automatic expectStay(input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) @(negedge clk);
    check(busOff === 1'b1 && errCntReset === 1'b0, tag, int'(busOff), 1);
  endtask

  initial begin
    int total;
    total = RUN_LEN * RUN_COUNT;
    repeat (3) @(negedge clk);
    check(busOff === 1'b0 && errCntReset === 1'b0, "R1 reset", int'(busOff), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busOff === 1'b0 && errCntReset === 1'b0, "R1 after release", int'(busOff), 0);

    // R11: bits before entry are not counted
    feed(total, 1'b1, 1'b0);
    check(busOff === 1'b0, "R11 idle bits no effect", int'(busOff), 0);

    // R3/R5: automatic, contiguous bits
    enter(1'b1);
    feed(total - 1, 1'b1, 1'b0);
    expectStay(2, "R3 one bit short");
    feed(1, 1'b1, 1'b0);
    expectExit(1, "R3 R5 auto");

    // R4: sweep dominant position inside the last run
    for (int pos = 0; pos < RUN_LEN; pos++) begin
      enter(1'b1);
      feed(total - RUN_LEN, 1'b1, 1'b0);
      if (pos > 0) feed(pos, 1'b1, 1'b0);
      feed(1, 1'b0, 1'b0);
      feed(RUN_LEN - 1, 1'b1, 1'b0);
      expectStay(2, "R4 partial run discarded");
      feed(1, 1'b1, 1'b0);
      expectExit(1, "R4 sweep");
    end

    // R6: invalid dominant cycles between valid bits
    enter(1'b1);
    feed(total - 1, 1'b1, 1'b1);
    expectStay(1, "R6 gaps one bit short");
    feed(1, 1'b1, 1'b0);
    expectExit(1, "R6 gaps");

    // R7/R9: manual, handshake after the runs (with extra runs: saturation R5)
    enter(1'b0);
    feed(total + 3 * RUN_LEN, 1'b1, 1'b0);
    expectStay(4, "R7 no handshake");
    @(negedge clk); initReq = 1'b1;
    expectStay(6, "R9 held high");
    initReq = 1'b0;
    expectExit(2, "R7 R5 manual late handshake");

    // R8: manual, handshake before the runs
    enter(1'b0);
    @(negedge clk); initReq = 1'b1;
    @(negedge clk); initReq = 1'b0;
    feed(total - 1, 1'b1, 1'b0);
    expectStay(2, "R8 one bit short");
    feed(1, 1'b1, 1'b0);
    expectExit(1, "R8 early handshake");

    // R9: level low throughout
    enter(1'b0);
    feed(total, 1'b1, 1'b0);
    expectStay(8, "R9 held low");

    // R11: re-entry clears runs and handshake; R2 entry while in bus-off
    enter(1'b0);
    @(negedge clk); initReq = 1'b1;
    @(negedge clk); initReq = 1'b0;
    feed(100 * RUN_LEN, 1'b1, 1'b0);
    enter(1'b1);
    autoRecover = 1'b0;
    feed(total, 1'b1, 1'b0);
    expectStay(4, "R11 handshake cleared");
    autoRecover = 1'b1;
    expectExit(1, "R11 auto after mode change");
    enter(1'b1);
    feed(total - RUN_LEN, 1'b1, 1'b0);
    expectStay(2, "R11 count restarted");
    feed(RUN_LEN, 1'b1, 1'b0);
    expectExit(1, "R11 full recount");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule